// File: doc/BRIEF.md
# Flag-Generating Byte/Word ALU

This block carries out the arithmetic, logic, shift and byte-manipulation operations of a 16-bit two-operand instruction set. Each request presents the instruction word, a byte/word select, the source value, the destination value and the current carry flag. One clock later the block returns the result, a strobe that says whether the destination should be written, a strobe that says whether the status flags should be updated, the new carry, zero, negative and overflow flags, and a marker for encodings it does not execute.

Operand fetch, address generation, stack traffic and branches are handled elsewhere. The surrounding core resolves both operands first and presents them to this block. For single-operand instructions the operand arrives on the destination input. The core then applies the returned strobes to its register file and status register. Decimal addition is reported as unsupported and has no effect.

Top module: `flag_alu`

## Requirements
- R1: When `insn[15:12]` is 4 through 15, the instruction is a two-operand operation. The values decode as 4 move, 5 add, 6 add-with-carry, 7 subtract-with-carry, 8 subtract, 9 compare, 10 decimal add, 11 bit test, 12 bit clear, 13 bit set, 14 exclusive-or and 15 and. When `insn[15:10]` is 000100, the instruction is a single-operand operation, and `insn[9:7]` decodes as 0 rotate-through-carry, 1 byte swap, 2 arithmetic shift right and 3 sign extend. Every other encoding is unsupported.
- R2: Move, bit clear (dst & ~src) and bit set (dst | src) assert `wr_en` and deassert `flags_we`. Whenever `flags_we` is 0, all four flag outputs read 0.
- R3: Add computes dst + src, and add-with-carry computes dst + src + `carry_in`. C is the carry out of the top bit of the selected width. V is set when both adder inputs have the same sign and the result's sign differs from that sign.
- R4: Subtract computes dst + ~src + 1, and subtract-with-carry computes dst + ~src + `carry_in`. C and V follow the adder rules of R3 applied to dst and ~src, so C is 1 when no borrow occurs.
- R5: Compare (same arithmetic as subtract) and bit test (dst & src) assert `flags_we` and deassert `wr_en`.
- R6: For every operation that updates the flags, N equals the top bit of the result (bit 7 in byte mode, bit 15 in word mode), and Z is set when the result is zero within the selected width.
- R7: And, bit test and exclusive-or set C when the result is nonzero. Exclusive-or sets V when both operands are negative. And and bit test clear V.
- R8: Rotate-through-carry and arithmetic shift right move the old bit 0 into C and clear V. Rotate places `carry_in` in the top bit, while the arithmetic shift keeps the old sign bit.
- R9: Byte swap exchanges the two bytes and leaves the flags untouched. Sign extend copies bit 7 into bits 15:8, sets C when the result is nonzero and clears V. Both are word-only, so in byte mode they are unsupported.
- R10: In byte mode (`byte_op` = 1), `result[15:8]` is always 0.
- R11: For an unsupported encoding, including decimal add, `unsupported` is 1, `wr_en` and `flags_we` are 0, and `result` is 0.
- R12: Outputs for a request accepted with `in_valid` appear with `out_valid` one clock later. On any cycle without a request, and after reset, `out_valid`, `wr_en`, `flags_we`, `unsupported` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| insn | input | 16 | Instruction word |
| byte_op | input | 1 | 1 selects byte width, 0 selects word width |
| src_val | input | 16 | Source operand |
| dst_val | input | 16 | Destination operand (the operand for single-operand instructions) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe, one clock after the request |
| result | output | 16 | Computed value |
| wr_en | output | 1 | Write the result to the destination |
| flags_we | output | 1 | Update the status flags |
| flag_c | output | 1 | New carry |
| flag_z | output | 1 | New zero |
| flag_n | output | 1 | New negative |
| flag_v | output | 1 | New overflow |
| unsupported | output | 1 | Encoding not executed |

## Verification
The interesting collision is an operation that consumes the incoming carry and produces an outgoing carry in the same cycle. This happens in rotate-through-carry, where `carry_in` fills the top bit while old bit 0 becomes the new C, and in subtract-with-carry at a sign boundary, where carry and overflow are both produced. These are provoked with operands whose old bit 0 and `carry_in` are both 1, and with 0x8000 minus 1 with carry clear. The bench then compares the result and all four flags against values worked out by hand from the requirements. A second collision, byte width combined with a word-only operation, is judged by checking that the block reports the request as unsupported and writes nothing.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;
    localparam int INSN_W = 16;
    localparam int MAJ_W  = 4;
    localparam int SUB_W  = 3;
    localparam logic [5:0] SINGLE_PFX = 6'b000100;

    typedef enum logic [3:0] {
        OP_MOV, OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP, OP_BIT, OP_BIC,
        OP_BIS, OP_XOR, OP_AND, OP_RRC, OP_SWPB, OP_RRA, OP_SXT, OP_BAD
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              c;
        logic              v;
    } path_t;

    function automatic logic op_writes(alu_op_e op);
        case (op)
            OP_CMP, OP_BIT, OP_BAD: return 1'b0;
            default:                return 1'b1;
        endcase
    endfunction

    function automatic logic op_sets_flags(alu_op_e op);
        case (op)
            OP_MOV, OP_BIC, OP_BIS, OP_SWPB, OP_BAD: return 1'b0;
            default:                                 return 1'b1;
        endcase
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return op inside {OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP};
    endfunction

    function automatic logic [DATA_W-1:0] fit_width(logic [DATA_W-1:0] x, logic byte_m);
        return byte_m ? {{(DATA_W-HALF_W){1'b0}}, x[HALF_W-1:0]} : x;
    endfunction

    function automatic logic sign_of(logic [DATA_W-1:0] x, logic byte_m);
        return byte_m ? x[HALF_W-1] : x[DATA_W-1];
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              byte_op,
    output alu_op_e           op
);
    logic [MAJ_W-1:0] major;
    logic [SUB_W-1:0] minor;

    assign major = insn[INSN_W-1 -: MAJ_W];
    assign minor = insn[9:7];

    always_comb begin
        op = OP_BAD;
        if (major >= MAJ_W'(4)) begin
            case (major)
                4'd4:    op = OP_MOV;
                4'd5:    op = OP_ADD;
                4'd6:    op = OP_ADDC;
                4'd7:    op = OP_SUBC;
                4'd8:    op = OP_SUB;
                4'd9:    op = OP_CMP;
                4'd11:   op = OP_BIT;
                4'd12:   op = OP_BIC;
                4'd13:   op = OP_BIS;
                4'd14:   op = OP_XOR;
                4'd15:   op = OP_AND;
                default: op = OP_BAD;
            endcase
        end else if (insn[INSN_W-1 -: 6] == SINGLE_PFX) begin
            case (minor)
                3'd0:    op = OP_RRC;
                3'd1:    op = byte_op ? OP_BAD : OP_SWPB;
                3'd2:    op = OP_RRA;
                3'd3:    op = byte_op ? OP_BAD : OP_SXT;
                default: op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = W / 2
) (
    input  alu_op_e      op,
    input  logic         byte_op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    input  logic         carry_in,
    output path_t        res
);
    logic         subtract;
    logic         cin_eff;
    logic [W-1:0] addend;
    logic [W:0]   sum_word;
    logic [HW:0]  sum_byte;
    logic [W-1:0] value;
    logic         sa, sb, sr;

    assign subtract = op inside {OP_SUBC, OP_SUB, OP_CMP};
    assign addend   = subtract ? ~src : src;

    always_comb begin
        case (op)
            OP_ADDC, OP_SUBC: cin_eff = carry_in;
            OP_SUB, OP_CMP:   cin_eff = 1'b1;
            default:          cin_eff = 1'b0;
        endcase
    end

    assign sum_word = {1'b0, dst} + {1'b0, addend} + {{W{1'b0}}, cin_eff};
    assign sum_byte = {1'b0, dst[HW-1:0]} + {1'b0, addend[HW-1:0]} + {{HW{1'b0}}, cin_eff};
    assign value    = byte_op ? {{(W-HW){1'b0}}, sum_byte[HW-1:0]} : sum_word[W-1:0];

    assign sa = sign_of(dst, byte_op);
    assign sb = sign_of(addend, byte_op);
    assign sr = sign_of(value, byte_op);

    assign res.value = value;
    assign res.c     = byte_op ? sum_byte[HW] : sum_word[W];
    assign res.v     = (sa == sb) && (sr != sa);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = W / 2
) (
    input  alu_op_e      op,
    input  logic         byte_op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    input  logic         carry_in,
    output path_t        res
);
    logic [W-1:0] raw;
    logic [W-1:0] value;
    logic         top_in;

    assign top_in = sign_of(dst, byte_op);

    always_comb begin
        raw = '0;
        case (op)
            OP_MOV:          raw = src;
            OP_BIC:          raw = dst & ~src;
            OP_BIS:          raw = dst | src;
            OP_XOR:          raw = dst ^ src;
            OP_AND, OP_BIT:  raw = dst & src;
            OP_RRC, OP_RRA: begin
                raw = dst >> 1;
                if (byte_op) raw[HW-1] = (op == OP_RRC) ? carry_in : top_in;
                else         raw[W-1]  = (op == OP_RRC) ? carry_in : top_in;
            end
            OP_SWPB:         raw = {dst[HW-1:0], dst[W-1:HW]};
            OP_SXT:          raw = {{(W-HW){dst[HW-1]}}, dst[HW-1:0]};
            default:         raw = '0;
        endcase
    end

    assign value = fit_width(raw, byte_op);

    always_comb begin
        res.value = value;
        res.c     = 1'b0;
        res.v     = 1'b0;
        case (op)
            OP_RRC, OP_RRA:                 res.c = dst[0];
            OP_AND, OP_BIT, OP_SXT:         res.c = |value;
            OP_XOR: begin
                res.c = |value;
                res.v = sign_of(src, byte_op) & sign_of(dst, byte_op);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic              byte_op,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flags_we,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v,
    output logic              unsupported
);
    alu_op_e           op;
    path_t             arith_res;
    path_t             logic_res;
    path_t             sel;
    flags_t            fl_next;
    logic [DATA_W-1:0] value_next;
    logic              byte_q;

    alu_decode u_decode (
        .insn    (insn),
        .byte_op (byte_op),
        .op      (op)
    );

    alu_arith #(.W(DATA_W), .HW(HALF_W)) u_arith (
        .op       (op),
        .byte_op  (byte_op),
        .src      (src_val),
        .dst      (dst_val),
        .carry_in (carry_in),
        .res      (arith_res)
    );

    alu_logic #(.W(DATA_W), .HW(HALF_W)) u_logic (
        .op       (op),
        .byte_op  (byte_op),
        .src      (src_val),
        .dst      (dst_val),
        .carry_in (carry_in),
        .res      (logic_res)
    );

    assign sel        = op_is_arith(op) ? arith_res : logic_res;
    assign value_next = (op == OP_BAD) ? '0 : sel.value;

    always_comb begin
        fl_next = '0;
        if (op_sets_flags(op)) begin
            fl_next.c = sel.c;
            fl_next.v = sel.v;
            fl_next.n = sign_of(value_next, byte_op);
            fl_next.z = (fit_width(value_next, byte_op) == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid   <= 1'b0;
            result      <= '0;
            wr_en       <= 1'b0;
            flags_we    <= 1'b0;
            {flag_c, flag_z, flag_n, flag_v} <= '0;
            unsupported <= 1'b0;
            byte_q      <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            result      <= value_next;
            wr_en       <= op_writes(op);
            flags_we    <= op_sets_flags(op);
            {flag_c, flag_z, flag_n, flag_v} <= fl_next;
            unsupported <= (op == OP_BAD);
            byte_q      <= byte_op;
        end
    end

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == OP_ADD && !byte_op
        |=> {flag_c, result} == $past({1'b0, dst_val} + {1'b0, src_val}));

    // R4
    sub_identity_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == OP_SUB && !byte_op
        |=> result == $past(dst_val - src_val));

    // R8
    rrc_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == OP_RRC |=> flag_c == $past(dst_val[0]));

    // R10
    byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && byte_q |-> result[DATA_W-1:HALF_W] == '0);

    // R11
    bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> !wr_en && !flags_we && result == '0);

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !flags_we |-> !flag_c && !flag_z && !flag_n && !flag_v);
endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] insn = '0;
    logic        byte_op = 1'b0;
    logic [15:0] src_val = '0;
    logic [15:0] dst_val = '0;
    logic        carry_in = 1'b0;
    logic        out_valid, wr_en, flags_we, flag_c, flag_z, flag_n, flag_v, unsupported;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;

    flag_alu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .byte_op(byte_op),
        .src_val(src_val), .dst_val(dst_val), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .flags_we(flags_we),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
        .unsupported(unsupported)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] two(int code);
        return {4'(code), 12'h000};
    endfunction

    function automatic logic [15:0] one(int code);
        return {6'b000100, 3'(code), 7'h00};
    endfunction

    // layout: result, wr, fwe, c, z, n, v, unsupported, valid
    function automatic logic [23:0] pk(logic [15:0] r, logic wr, logic fwe,
                                       logic c, logic z, logic n, logic v, logic bad);
        return {r, wr, fwe, c, z, n, v, bad, 1'b1};
    endfunction

    task automatic chk(string tag, logic [23:0] exp);
        logic [23:0] act;
        act = {result, wr_en, flags_we, flag_c, flag_z, flag_n, flag_v, unsupported, out_valid};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [15:0] i, logic b, logic [15:0] s, logic [15:0] d, logic ci);
        @(negedge clk);
        insn = i; byte_op = b; src_val = s; dst_val = d; carry_in = ci; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 reset state", 24'h0);
    endtask

    task automatic t_moves();
        issue(two(4), 0, 16'h1234, 16'hffff, 1);
        chk("R2 mov", pk(16'h1234, 1, 0, 0, 0, 0, 0, 0));
        issue(two(12), 0, 16'h00ff, 16'h1234, 0);
        chk("R2 bic", pk(16'h1200, 1, 0, 0, 0, 0, 0, 0));
        issue(two(13), 0, 16'h0f00, 16'h1234, 0);
        chk("R2 bis", pk(16'h1f34, 1, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_add();
        issue(two(5), 0, 16'h7fff, 16'h0001, 1);
        chk("R3 add overflow", pk(16'h8000, 1, 1, 0, 0, 1, 1, 0));
        issue(two(5), 0, 16'hffff, 16'h0001, 0);
        chk("R3 R6 add wrap zero", pk(16'h0000, 1, 1, 1, 1, 0, 0, 0));
        issue(two(6), 1, 16'h00ff, 16'h5500, 1);
        chk("R3 R10 addc byte", pk(16'h0000, 1, 1, 1, 1, 0, 0, 0));
    endtask

    task automatic t_sub();
        issue(two(8), 0, 16'h0007, 16'h0005, 1);
        chk("R4 sub borrow", pk(16'hfffe, 1, 1, 0, 0, 1, 0, 0));
        issue(two(7), 0, 16'h0001, 16'h8000, 0);
        chk("R4 subc overflow", pk(16'h7ffe, 1, 1, 1, 0, 0, 1, 0));
        issue(two(9), 1, 16'h3342, 16'h1242, 0);
        chk("R5 cmp byte equal", pk(16'h0000, 0, 1, 1, 1, 0, 0, 0));
    endtask

    task automatic t_logic();
        issue(two(11), 0, 16'h8000, 16'h8001, 0);
        chk("R5 R7 bit", pk(16'h8000, 0, 1, 1, 0, 1, 0, 0));
        issue(two(14), 0, 16'h8000, 16'h8000, 0);
        chk("R7 xor negatives", pk(16'h0000, 1, 1, 0, 1, 0, 1, 0));
        issue(two(15), 1, 16'h000f, 16'h00f0, 1);
        chk("R7 and byte zero", pk(16'h0000, 1, 1, 0, 1, 0, 0, 0));
        issue(two(14), 1, 16'h9981, 16'h2280, 0);
        chk("R7 R10 xor byte", pk(16'h0001, 1, 1, 1, 0, 0, 1, 0));
    endtask

    task automatic t_shift();
        issue(one(0), 0, 16'h0000, 16'h0001, 1);
        chk("R8 rrc carry in and out", pk(16'h8000, 1, 1, 1, 0, 1, 0, 0));
        issue(one(0), 1, 16'h0000, 16'hab02, 0);
        chk("R8 R10 rrc byte", pk(16'h0001, 1, 1, 0, 0, 0, 0, 0));
        issue(one(2), 0, 16'h0000, 16'h8003, 0);
        chk("R8 rra word", pk(16'hc001, 1, 1, 1, 0, 1, 0, 0));
        issue(one(2), 1, 16'h0000, 16'h0081, 0);
        chk("R8 rra byte", pk(16'h00c0, 1, 1, 1, 0, 1, 0, 0));
    endtask

    task automatic t_swap_sxt();
        issue(one(1), 0, 16'h0000, 16'h12ab, 1);
        chk("R9 swpb", pk(16'hab12, 1, 0, 0, 0, 0, 0, 0));
        issue(one(3), 0, 16'h0000, 16'h1280, 0);
        chk("R9 sxt negative", pk(16'hff80, 1, 1, 1, 0, 1, 0, 0));
        issue(one(3), 0, 16'h0000, 16'h7f00, 0);
        chk("R9 sxt zero", pk(16'h0000, 1, 1, 0, 1, 0, 0, 0));
        issue(one(1), 1, 16'h0000, 16'h12ab, 0);
        chk("R9 swpb byte rejected", pk(16'h0000, 0, 0, 0, 0, 0, 0, 1));
    endtask

    task automatic t_bad();
        issue(two(10), 0, 16'h0011, 16'h0022, 1);
        chk("R11 decimal add", pk(16'h0000, 0, 0, 0, 0, 0, 0, 1));
        issue(16'h2000, 0, 16'h0011, 16'h0022, 0);
        chk("R1 R11 jump encoding", pk(16'h0000, 0, 0, 0, 0, 0, 0, 1));
        issue(one(4), 0, 16'h0011, 16'h0022, 0);
        chk("R1 R11 single op 4", pk(16'h0000, 0, 0, 0, 0, 0, 0, 1));
    endtask

    task automatic t_idle();
        issue(two(4), 0, 16'h5a5a, 16'h0000, 0);
        @(negedge clk);
        chk("R12 idle after request", 24'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_moves();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_swap_sxt();
        t_bad();
        t_idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule